// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog timer with a single 8-bit control register on a simple strobe-qualified register bus. The register is protected against stray writes by a two-step sequence. A first write sets an arm bit. The very next bus access, if it is a write with the arm bit clear, is the only one that updates the register. Any other access in between cancels the sequence.

The timeout is a base tick count scaled by a power of two that a 4-bit prescale field selects. When the count runs out, the block behaves in one of two ways. In reset mode it emits a one-cycle reset pulse, which also returns the block to its defaults. In interrupt mode it sets a pending flag on an interrupt output that nothing can mask, so the block can also serve as a long-interval periodic timer. Software restarts the count by writing a kick bit through the protected sequence.

A nonvolatile lock input is captured during external reset. When it reads low, the watchdog is pinned on and in reset mode, but the prescale field can still be changed. The same captured bit selects the default protection key value, which the block presents on a read-only output.

Top module: `guarded_wdt`

## Requirements
- R1: A write with bit 3 (arm) set only arms the sequence and changes no other field. Only the access that immediately follows it, if that access is a write with bit 3 clear, is applied to the register. A read, or any access other than an arming write, clears the armed state.
- R2: A write with bit 3 clear that does not directly follow an arming write leaves enable, mode and prescale unchanged.
- R3: In reset mode (bit 1 = 0, bit 0 = 1), `wdt_rst` goes high for exactly one cycle, BASE_TICKS × 2^min(PRE,11) clock edges after the last kick or reset. The next cycle reads back the defaults 0xB1 (prescale 11, interrupt mode off, enabled, nothing pending).
- R4: In interrupt mode (bit 1 = 1), expiry sets `wdt_irq` after the same interval and no reset pulse occurs. The counter restarts, and the flag stays set until a kick clears it.
- R5: An applied write with bit 2 (kick) set restarts the timeout interval and clears `wdt_irq`.
- R6: Prescale values 12 to 15 give the same timeout as 11, but read back as written.
- R7: When `nv_lock_n` was low at the last external reset, enable reads 1 and mode reads 0 whatever is written. Expiry then always produces a reset pulse. Bits 7:4 (prescale) still accept protected writes.
- R8: `key_default` is 0x7F when locked and 0xFF when unlocked, and it stays fixed between external resets.
- R9: Read data is {prescale[7:4], 0 at bit 3, irq-pending at bit 2, mode at bit 1, enable at bit 0}. The arm bit always reads 0.
- R10: With enable at 0, no reset pulse and no interrupt are produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low external reset |
| nv_lock_n | input | 1 | Nonvolatile lock bit, active low, captured during external reset |
| acc_stb | input | 1 | Bus access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Control register read-back |
| key_default | output | 8 | Default protection key selected by the lock bit |
| wdt_rst | output | 1 | One-cycle system reset request on expiry |
| wdt_irq | output | 1 | Watchdog interrupt pending, not maskable |

## Verification
The hardest case to reach is the boundary in the write sequence: the arm must be broken by an intervening read and must still apply on the very next write. The stimulus arms, reads, then writes an unarmed value and checks that the register did not move. The locked configuration can only be reached by a second external reset with the lock input low. After it, a write that tries to disable the watchdog and select interrupt mode must change only the prescale field. An expiry must then still end in a reset pulse at the exact prescaled interval.

// File: rtl/guarded_wdt_pkg.sv
// Package: shared field positions and types for the guarded watchdog.
// Assumes an 8-bit control register; positions are decoded by software.
package guarded_wdt_pkg;
    localparam int REG_W    = 8;
    localparam int PRE_W    = 4;
    localparam int ENA_BIT  = 0;
    localparam int MODE_BIT = 1;
    localparam int KICK_BIT = 2;
    localparam int ARM_BIT  = 3;
    localparam int PRE_LSB  = 4;

    // Effective control settings after lock forcing
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             irq_mode;
        logic             enable;
    } wdt_ctrl_t;
endpackage

// File: rtl/gwd_unlock.sv
// Module: two-step write guard. An arming write sets arm_q; the next access
// commits only if it is a write without the arm bit. Any access other than an
// arming write clears arm_q. Assumes one-cycle access strobes.
module gwd_unlock (
    input  logic clk,
    input  logic srst_n,
    input  logic acc_stb,
    input  logic acc_wr,
    input  logic arm_bit,
    output logic arm_q,
    output logic commit
);
    // Track the armed state across bus accesses
    always_ff @(posedge clk) begin
        if (!srst_n)
            arm_q <= 1'b0;
        else if (acc_stb)
            arm_q <= acc_wr && arm_bit;
    end

    // A write with the arm bit clear, directly after arming, is applied
    assign commit = acc_stb && acc_wr && !arm_bit && arm_q;
endmodule

// File: rtl/gwd_ctrl.sv
// Module: control register storage with lock forcing. The lock pins enable
// to 1 and mode to 0 and blocks their writes; prescale stays writable.
// Assumes lock_n is stable between external resets.
module gwd_ctrl
    import guarded_wdt_pkg::*;
#(
    parameter logic [PRE_W-1:0] PRE_RST = 4'd11
) (
    input  logic             clk,
    input  logic             srst_n,
    input  logic             lock_n,
    input  logic             commit,
    input  logic [PRE_W-1:0] wr_pre,
    input  logic             wr_mode,
    input  logic             wr_en,
    input  logic             wr_kick,
    output wdt_ctrl_t        ctrl,
    output logic             kick
);
    logic [PRE_W-1:0] pre_q;
    logic             mode_q;
    logic             en_q;

    // Store the prescale field; always writable through the guard
    always_ff @(posedge clk) begin
        if (!srst_n)
            pre_q <= PRE_RST;
        else if (commit)
            pre_q <= wr_pre;
    end

    // Store enable and mode; writes blocked while locked
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            en_q   <= 1'b1;
            mode_q <= 1'b0;
        end else if (commit && lock_n) begin
            en_q   <= wr_en;
            mode_q <= wr_mode;
        end
    end

    // Effective settings seen by the timer and the read path
    always_comb begin
        ctrl.pre      = pre_q;
        ctrl.enable   = en_q | ~lock_n;
        ctrl.irq_mode = mode_q & lock_n;
    end

    assign kick = commit && wr_kick;
endmodule

// File: rtl/gwd_timer.sv
// Module: prescaled timeout counter with reset-pulse or interrupt expiry.
// Timeout = BASE_TICKS << min(pre, PRE_MAX) edges. The counter compares with
// >= so that shrinking the timeout mid-count still expires at once.
// Assumes srst_n includes the block's own reset pulse.
module gwd_timer
    import guarded_wdt_pkg::*;
#(
    parameter int BASE_TICKS = 16,
    parameter int PRE_MAX    = 11
) (
    input  logic      clk,
    input  logic      srst_n,
    input  wdt_ctrl_t ctrl,
    input  logic      kick,
    output logic      rst_q,
    output logic      irq_q
);
    localparam int CNT_W = $clog2(BASE_TICKS) + PRE_MAX + 1;
    localparam logic [PRE_W-1:0] PRE_CAP = PRE_W'(PRE_MAX);

    logic [CNT_W-1:0] lim_tab [0:PRE_MAX];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_m1;
    logic [PRE_W-1:0] pre_sat;
    logic             expire;

    // Build the timeout table, one entry per prescale step
    for (genvar g = 0; g <= PRE_MAX; g++) begin : g_lim
        assign lim_tab[g] = CNT_W'(BASE_TICKS) << g;
    end

    // Saturate the prescale selection and look up the limit
    always_comb begin
        pre_sat = (ctrl.pre > PRE_CAP) ? PRE_CAP : ctrl.pre;
        lim_m1  = lim_tab[pre_sat] - 1'b1;
        expire  = ctrl.enable && !kick && (cnt_q >= lim_m1);
    end

    // Count enabled cycles; restart on kick, disable or expiry
    always_ff @(posedge clk) begin
        if (!srst_n || !ctrl.enable || kick || expire)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // One-cycle reset request; it clears itself through srst_n
    always_ff @(posedge clk) begin
        if (!srst_n)
            rst_q <= 1'b0;
        else
            rst_q <= expire && !ctrl.irq_mode;
    end

    // Pending interrupt flag; kick wins over a simultaneous expiry
    always_ff @(posedge clk) begin
        if (!srst_n || kick)
            irq_q <= 1'b0;
        else if (expire && ctrl.irq_mode)
            irq_q <= 1'b1;
    end
endmodule

// File: rtl/guarded_wdt.sv
// Module: top of the guarded watchdog. Combines the write guard, control
// register and timer; captures the lock input during external reset and
// presents the default protection key. Internal state also resets on the
// block's own reset pulse, the lock capture does not.
module guarded_wdt
    import guarded_wdt_pkg::*;
#(
    parameter int               BASE_TICKS = 16,
    parameter int               PRE_MAX    = 11,
    parameter logic [PRE_W-1:0] PRE_RST    = 4'd11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nv_lock_n,
    input  logic             acc_stb,
    input  logic             acc_wr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] key_default,
    output logic             wdt_rst,
    output logic             wdt_irq
);
    logic      srst_n;
    logic      lock_n_q;
    logic      arm_q;
    logic      commit;
    logic      kick;
    wdt_ctrl_t ctrl;

    assign srst_n = rst_n && !wdt_rst;

    // Capture the nonvolatile lock bit while external reset is held
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_n_q <= nv_lock_n;
    end

    gwd_unlock u_unlock (
        .clk     (clk),
        .srst_n  (srst_n),
        .acc_stb (acc_stb),
        .acc_wr  (acc_wr),
        .arm_bit (wr_data[ARM_BIT]),
        .arm_q   (arm_q),
        .commit  (commit)
    );

    gwd_ctrl #(
        .PRE_RST (PRE_RST)
    ) u_ctrl (
        .clk     (clk),
        .srst_n  (srst_n),
        .lock_n  (lock_n_q),
        .commit  (commit),
        .wr_pre  (wr_data[PRE_LSB +: PRE_W]),
        .wr_mode (wr_data[MODE_BIT]),
        .wr_en   (wr_data[ENA_BIT]),
        .wr_kick (wr_data[KICK_BIT]),
        .ctrl    (ctrl),
        .kick    (kick)
    );

    gwd_timer #(
        .BASE_TICKS (BASE_TICKS),
        .PRE_MAX    (PRE_MAX)
    ) u_timer (
        .clk    (clk),
        .srst_n (srst_n),
        .ctrl   (ctrl),
        .kick   (kick),
        .rst_q  (wdt_rst),
        .irq_q  (wdt_irq)
    );

    // Read-back layout; the arm position always reads 0
    always_comb begin
        rd_data                       = '0;
        rd_data[PRE_LSB +: PRE_W]     = ctrl.pre;
        rd_data[KICK_BIT]             = wdt_irq;
        rd_data[MODE_BIT]             = ctrl.irq_mode;
        rd_data[ENA_BIT]              = ctrl.enable;
    end

    assign key_default = {lock_n_q, 7'h7F};
endmodule

// File: rtl/guarded_wdt_chk.sv
// Module: property checker for the guarded watchdog, bound to the top.
// Observes ports plus the arm and lock state of the top module.
module guarded_wdt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_stb,
    input logic       acc_wr,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [7:0] key_default,
    input logic       wdt_rst,
    input logic       wdt_irq,
    input logic       arm_q,
    input logic       lock_n_q
);
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);                                             // R3

    AST_RST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> (rd_data == 8'hB1 && !wdt_irq));                       // R3

    AST_RST_NEEDS_RESET_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst) |-> ($past(rd_data[1:0]) == 2'b01));                // R4

    AST_UNARMED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && acc_wr && !arm_q && !wr_data[3] && !wdt_rst)
        |=> ($stable(rd_data[7:4]) && $stable(rd_data[1:0])));             // R2

    AST_NON_ARM_ACCESS_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && !(acc_wr && wr_data[3])) |=> !arm_q);                  // R1

    AST_KICK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && acc_wr && arm_q && !wr_data[3] && wr_data[2]) |=> !wdt_irq); // R5

    AST_LOCK_PINS_CONFIG: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_n_q |-> (rd_data[1:0] == 2'b01));                            // R7

    AST_KEY_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(key_default));                                    // R8
endmodule

bind guarded_wdt guarded_wdt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_stb     (acc_stb),
    .acc_wr      (acc_wr),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .key_default (key_default),
    .wdt_rst     (wdt_rst),
    .wdt_irq     (wdt_irq),
    .arm_q       (arm_q),
    .lock_n_q    (lock_n_q)
);

// File: tb/guarded_wdt_tb.sv
`timescale 1ns/1ps
module guarded_wdt_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nv_lock_n = 1'b1;
    logic       acc_stb = 1'b0;
    logic       acc_wr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [7:0] key_default;
    logic       wdt_rst;
    logic       wdt_irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        logic [7:0] exp;
    } rd_item_t;
    rd_item_t sb_q[$];

    localparam int BASE = 16;

    guarded_wdt u_dut (
        .clk(clk), .rst_n(rst_n), .nv_lock_n(nv_lock_n),
        .acc_stb(acc_stb), .acc_wr(acc_wr), .wr_data(wr_data),
        .rd_data(rd_data), .key_default(key_default),
        .wdt_rst(wdt_rst), .wdt_irq(wdt_irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int tmo(input int pre);
        return BASE << ((pre > 11) ? 11 : pre);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] d);
        @(negedge clk);
        acc_stb = 1'b1; acc_wr = 1'b1; wr_data = d;
        @(negedge clk);
        acc_stb = 1'b0; acc_wr = 1'b0; wr_data = 8'h00;
    endtask

    // Protected write; returns the edge number at which it took effect
    task automatic prot_write(input logic [7:0] d, output int at);
        bus_write(8'h08);
        bus_write(d);
        at = cyc;
    endtask

    // Driver: issue a read and push the expected value to the scoreboard
    task automatic bus_read(input logic [7:0] exp, input string req);
        rd_item_t it;
        @(negedge clk);
        acc_stb = 1'b1; acc_wr = 1'b0;
        it.req = req; it.exp = exp;
        sb_q.push_back(it);
        @(negedge clk);
        acc_stb = 1'b0;
    endtask

    // Monitor: compare read data while a read strobe is active
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (acc_stb && !acc_wr && sb_q.size() > 0) begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(rd_data === it.exp, it.req, int'(rd_data), int'(it.exp));
            end
        end
    end

    // Wait for a reset pulse or interrupt; returns edge number or -1
    task automatic wait_event(input bit want_irq, input int limit, output int at, output bit saw_rst);
        at = -1; saw_rst = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (wdt_rst) saw_rst = 1'b1;
            if ((want_irq && wdt_irq) || (!want_irq && wdt_rst)) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic ext_reset(input logic lock_n);
        @(negedge clk);
        nv_lock_n = lock_n;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0x%0h expected=0x%0h", cyc, 0);
        finish_run();
    end

    initial begin
        int k, at;
        bit saw;

        ext_reset(1'b1);
        @(negedge clk);
        // R9 / R8: reset state, unlocked key
        check(wdt_rst == 1'b0 && wdt_irq == 1'b0, "R9 reset outputs", {wdt_rst, wdt_irq}, 0);
        check(key_default == 8'hFF, "R8 key unlocked", key_default, 8'hFF);
        bus_read(8'hB1, "R9 reset readback");

        // R2: write without arming is ignored
        bus_write(8'h33);
        bus_read(8'hB1, "R2 unarmed write ignored");

        // R1: protected write applies
        prot_write(8'h37, k);
        bus_read(8'h33, "R1 armed write applied");

        // R1: intervening read breaks the sequence
        bus_write(8'h08);
        bus_read(8'h33, "R1 readback between arm and write");
        bus_write(8'h20);
        bus_read(8'h33, "R1 arm broken by read");

        // R4: interrupt mode expiry, no reset
        prot_write(8'h37, k);
        wait_event(1'b1, 3 * tmo(3), at, saw);
        check(at - k == tmo(3), "R4 irq interval", at - k, tmo(3));
        check(!saw, "R4 no reset pulse in irq mode", saw, 0);
        bus_read(8'h37, "R9 irq pending visible");
        repeat (tmo(3) + 5) @(negedge clk);
        check(wdt_irq == 1'b1 && wdt_rst == 1'b0, "R4 flag held, no reset", {wdt_irq, wdt_rst}, 2);

        // R5: kick clears pending interrupt
        prot_write(8'h37, k);
        check(wdt_irq == 1'b0, "R5 kick clears irq", wdt_irq, 0);
        bus_read(8'h33, "R5 readback after kick");

        // R3: reset mode expiry, one-cycle pulse, defaults restored
        prot_write(8'h25, k);
        wait_event(1'b0, 3 * tmo(2), at, saw);
        check(at - k == tmo(2), "R3 reset interval", at - k, tmo(2));
        @(negedge clk);
        check(wdt_rst == 1'b0, "R3 pulse one cycle", wdt_rst, 0);
        bus_read(8'hB1, "R3 defaults after pulse");

        // R10: disabled watchdog stays silent
        prot_write(8'h04, k);
        bus_read(8'h00, "R10 disabled readback");
        wait_event(1'b0, 300, at, saw);
        check(at == -1 && wdt_irq == 1'b0, "R10 no event when disabled", at, -1);

        // R6: prescale saturation
        prot_write(8'hF5, k);
        bus_read(8'hF1, "R6 prescale readback raw");
        wait_event(1'b0, tmo(11) + 100, at, saw);
        check(at - k == tmo(11), "R6 saturated interval", at - k, tmo(11));

        // R7 / R8: locked configuration
        ext_reset(1'b0);
        @(negedge clk);
        check(key_default == 8'h7F, "R8 key locked", key_default, 8'h7F);
        bus_read(8'hB1, "R7 locked reset readback");
        prot_write(8'h32, k);
        bus_read(8'h31, "R7 only prescale changes");
        prot_write(8'h34, k);
        wait_event(1'b0, 3 * tmo(3), at, saw);
        check(at - k == tmo(3), "R7 locked expiry resets", at - k, tmo(3));
        check(key_default == 8'h7F, "R8 key fixed after pulse", key_default, 8'h7F);
        bus_read(8'hB1, "R7 defaults after locked pulse");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R9 scoreboard drained", sb_q.size(), 0);
        finish_run();
    end
endmodule